// File: doc/BRIEF.md
# Timed Instruction Injection Front End

This block sits between a test harness and a processor core's fetch port. The harness sends 64-bit injection tokens over a valid/ready stream. Each token carries an instruction word, a 16-bit timestamp and a command byte. An instruction token is held back for a number of clock cycles. That number is its timestamp minus the timestamp of the token before it. The instruction is then offered on a valid/ready fetch port. A token with a nonzero command byte is not an instruction. It produces a one-cycle command pulse, such as a request to reset the core under test, and it becomes the new time reference.

Back-pressure works in both directions. The input side is ready only when the block is idle. It is not ready while a delay counts down or while the fetch side still holds an instruction it has not taken. The fetch side keeps its valid signal and word steady until the core accepts them. The block does not decode or expand instructions. The instruction word goes out exactly as it came in.

Top module: `tinj_pacer`

## Requirements
- R1: Token fields are decoded as follows: bits 31:0 are the instruction word, bits 47:32 are the timestamp, and bits 55:48 are the command byte.
- R2: The first instruction token after reset has no time reference. It is presented with zero delay: fetch_valid is high in the cycle after the accepting edge.
- R3: For any later instruction token accepted at clock edge k, fetch_valid first becomes high after edge k+D. D is the token's timestamp minus the reference timestamp.
- R4: The subtraction for D wraps modulo 2^16.
- R5: A token with a nonzero command byte raises cmd_valid for exactly the one cycle after its accepting edge, with cmd_code equal to that byte. It presents no instruction, and tok_ready stays high.
- R6: Every accepted token, whether instruction or command, becomes the time reference for the next token.
- R7: tok_ready is low while a delay is counting down and while an instruction is presented. Otherwise it is high.
- R8: fetch_valid and fetch_insn hold steady until fetch_ready is seen high. In the cycle after that handshake, fetch_valid is low and tok_ready is high.
- R9: The instruction word, including a compressed instruction in its low 16 bits, appears on fetch_insn unchanged.
- R10: While reset is held, and right after it, tok_ready is 1, fetch_valid is 0 and cmd_valid is 0. Reset also clears any time reference and any pending delay.
- R11: Bits 63:56 of a token are ignored. A token with nonzero padding and a zero command byte behaves as an instruction token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token stream valid |
| tok_ready | output | 1 | Token stream ready |
| tok_data | input | 64 | Injection token |
| fetch_valid | output | 1 | Instruction offered to the core |
| fetch_ready | input | 1 | Core takes the instruction |
| fetch_insn | output | 32 | Instruction word |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 8 | Command byte for the pulse |

## Verification
Each result has a fixed latency.
- An instruction with delay D becomes visible after edge k+D, where k is the edge that accepts it.
- A command pulse is visible only in the cycle right after its accepting edge.
- A fetch handshake frees tok_ready one edge later.

The bench drives inputs on falling edges and reads every output at the falling edge after the edge that should update it. For instruction tokens it counts falling edges from acceptance until fetch_valid appears. That count must equal the hand-computed delay exactly, so a result one cycle early or one cycle late is reported.

// File: rtl/tinj_pkg.sv
package tinj_pkg;
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned TIME_W   = 16;
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned TOK_W    = 64;
  localparam int unsigned INSN_LSB = 0;
  localparam int unsigned TIME_LSB = INSN_LSB + INSN_W;
  localparam int unsigned CMD_LSB  = TIME_LSB + TIME_W;
  localparam int unsigned PAD_LSB  = CMD_LSB + CMD_W;
  localparam int unsigned PAD_W    = TOK_W - PAD_LSB;

  typedef struct packed {
    logic [PAD_W-1:0]  pad;
    logic [CMD_W-1:0]  cmd;
    logic [TIME_W-1:0] stamp;
    logic [INSN_W-1:0] insn;
  } tok_fields_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SHOW = 2'd2
  } pace_state_t;
endpackage

// File: rtl/tinj_unpack.sv
module tinj_unpack
  import tinj_pkg::*;
(
  input  logic [TOK_W-1:0] tok_data,
  output tok_fields_t      fields
);
  always_comb begin
    fields.insn  = tok_data[INSN_LSB +: INSN_W];
    fields.stamp = tok_data[TIME_LSB +: TIME_W];
    fields.cmd   = tok_data[CMD_LSB  +: CMD_W];
    fields.pad   = tok_data[PAD_LSB  +: PAD_W];
  end
endmodule

// File: rtl/tinj_delta.sv
module tinj_delta
  import tinj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] stamp,
  output logic [TIME_W-1:0] delta
);
  logic              have_ref;
  logic [TIME_W-1:0] ref_q;

  // Wrapping difference; zero while no reference exists.
  assign delta = have_ref ? (stamp - ref_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_ref <= 1'b0;
      ref_q    <= '0;
    end else if (load) begin
      have_ref <= 1'b1;
      ref_q    <= stamp;
    end
  end
endmodule

// File: rtl/tinj_timer.sv
module tinj_timer
  import tinj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TIME_W-1:0] count,
  output logic              expire
);
  logic [TIME_W-1:0] cnt_q;

  assign expire = (cnt_q == TIME_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= count;
    else if (cnt_q != '0)    cnt_q <= cnt_q - TIME_W'(1);
  end
endmodule

// File: rtl/tinj_pacer.sv
module tinj_pacer
  import tinj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [TOK_W-1:0]  tok_data,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [INSN_W-1:0] fetch_insn,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code
);
  tok_fields_t       fields;
  pace_state_t       state_q;
  logic [TIME_W-1:0] delta;
  logic              expire;
  logic              accept;
  logic              is_cmd;
  logic              wait_start;
  logic              pad_unused;

  tinj_unpack u_unpack (.tok_data(tok_data), .fields(fields));

  tinj_delta u_delta (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .stamp(fields.stamp), .delta(delta)
  );

  tinj_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(wait_start),
    .count(delta), .expire(expire)
  );

  assign pad_unused  = ^fields.pad;
  assign tok_ready   = (state_q == ST_IDLE);
  assign fetch_valid = (state_q == ST_SHOW);
  assign accept      = tok_valid && tok_ready;
  assign is_cmd      = (fields.cmd != '0);
  assign wait_start  = accept && !is_cmd && (delta != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fetch_insn <= '0;
      cmd_valid  <= 1'b0;
      cmd_code   <= '0;
    end else begin
      cmd_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (is_cmd) begin
            cmd_valid <= 1'b1;
            cmd_code  <= fields.cmd;
          end else begin
            fetch_insn <= fields.insn;
            state_q    <= (delta == '0) ? ST_SHOW : ST_WAIT;
          end
        end
        ST_WAIT: if (expire)      state_q <= ST_SHOW;
        ST_SHOW: if (fetch_ready) state_q <= ST_IDLE;
        default:                  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tinj_checker.sv
module tinj_checker
  import tinj_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic              tok_ready,
  input logic [TOK_W-1:0]  tok_data,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [INSN_W-1:0] fetch_insn,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_code
);
  logic [CMD_W-1:0] tok_cmd;
  logic             tok_unused;
  assign tok_cmd    = tok_data[CMD_LSB +: CMD_W];
  assign tok_unused = ^tok_data;

  assert_ready_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !tok_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_insn));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> !fetch_valid && tok_ready);

  assert_cmd_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(tok_valid && tok_ready) && (cmd_code == $past(tok_cmd)) && (cmd_code != '0));

  assert_cmd_nofetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !fetch_valid && tok_ready);
endmodule

bind tinj_pacer tinj_checker u_chk (.*);

// File: tb/tinj_pacer_test.sv
module tinj_pacer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tok_valid;
  logic        tok_ready;
  logic [63:0] tok_data;
  logic        fetch_valid;
  logic        fetch_ready;
  logic [31:0] fetch_insn;
  logic        cmd_valid;
  logic [7:0]  cmd_code;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tinj_pacer uut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_data(tok_data), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_insn(fetch_insn), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  typedef struct packed {
    logic [63:0] tok;
    logic        is_cmd;
    logic [15:0] dly;
  } vec_t;

  // pad | cmd | time | insn ; expected delays worked out by hand
  localparam vec_t VEC [10] = '{
    '{64'h00_00_0100_00A00093, 1'b0, 16'd0},  // R2 first token
    '{64'hFF_00_0104_12345678, 1'b0, 16'd4},  // R11 padding ignored
    '{64'h00_00_0104_DEADBEEF, 1'b0, 16'd0},  // equal stamps
    '{64'h00_01_0200_00000000, 1'b1, 16'd0},  // R5 reset command
    '{64'h00_00_0203_00004501, 1'b0, 16'd3},  // R6, R9 compressed
    '{64'h00_02_FFFE_00000000, 1'b1, 16'd0},
    '{64'h00_00_0003_FFFFFFFF, 1'b0, 16'd5},  // R4 wrap
    '{64'h00_7F_0010_00000000, 1'b1, 16'd0},
    '{64'h5A_80_0012_00000013, 1'b1, 16'd0},  // back-to-back commands
    '{64'h00_00_0014_00008082, 1'b0, 16'd2}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  // Returns at the falling edge after the accepting rising edge.
  task automatic send(input logic [63:0] t);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_data  = t;
    while (!tok_ready) @(negedge clk);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic take_insn(input logic [63:0] t, input logic [15:0] dly);
    int n = 0;
    check(tok_ready == 1'b0, "R7", "ready after accept", 64'(tok_ready), 64'd0);
    while (!fetch_valid && n < 70000) begin
      @(negedge clk);
      n++;
      if (!fetch_valid)
        check(tok_ready == 1'b0, "R7", "ready while waiting", 64'(tok_ready), 64'd0);
    end
    check(n == int'(dly), "R3", "delay cycles", 64'(n), 64'(dly));
    check(fetch_insn == t[31:0], "R9", "insn word", 64'(fetch_insn), 64'(t[31:0]));
    @(negedge clk);
    check(fetch_valid && fetch_insn == t[31:0], "R8", "hold without ready",
          64'(fetch_insn), 64'(t[31:0]));
    fetch_ready = 1'b1;
    @(negedge clk);
    fetch_ready = 1'b0;
    check(!fetch_valid && tok_ready, "R8", "release after take",
          64'({fetch_valid, tok_ready}), 64'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vecs++;
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tok_valid = 1'b0; tok_data = '0; fetch_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(tok_ready && !fetch_valid && !cmd_valid, "R10", "reset outputs",
          64'({tok_ready, fetch_valid, cmd_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(tok_ready && !fetch_valid && !cmd_valid, "R10", "after reset",
          64'({tok_ready, fetch_valid, cmd_valid}), 64'b100);

    for (int i = 0; i < 10; i++) begin
      send(VEC[i].tok);
      if (VEC[i].is_cmd) begin
        // R1, R5 command byte from bits 55:48
        check(cmd_valid && cmd_code == VEC[i].tok[55:48], "R5", "cmd pulse",
              64'({cmd_valid, cmd_code}), 64'({1'b1, VEC[i].tok[55:48]}));
        check(!fetch_valid && tok_ready, "R5", "cmd no fetch",
              64'({fetch_valid, tok_ready}), 64'b01);
        @(negedge clk);
        check(!cmd_valid, "R5", "pulse width", 64'(cmd_valid), 64'd0);
      end else begin
        take_insn(VEC[i].tok, VEC[i].dly);
      end
    end

    // Directed: reset during a wait (reference 0x0014, stamp 0x0040 -> 44)
    send(64'h00_00_0040_11111111);
    repeat (3) @(negedge clk);
    check(!tok_ready && !fetch_valid, "R7", "mid-wait state",
          64'({tok_ready, fetch_valid}), 64'b00);
    rst_n = 1'b0;
    @(negedge clk);
    check(tok_ready && !fetch_valid && !cmd_valid, "R10", "reset in wait",
          64'({tok_ready, fetch_valid, cmd_valid}), 64'b100);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check(!fetch_valid, "R10", "pending delay dropped", 64'(fetch_valid), 64'd0);
    // R2 reference cleared: far stamp still gives zero delay
    send(64'h00_00_9999_22222222);
    take_insn(64'h00_00_9999_22222222, 16'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule